// File: doc/BRIEF.md
# DLL delay code margin adjuster

This block sits between a delay-locked loop and one delayed-clock path. It takes the loop's 8-bit master delay code and produces an adjusted code. The adjusted code is the accepted master code plus a signed trim offset, saturated to the range 0 to 255. The trim offset is moved one step at a time by strobes on a move input. The offset can also be dropped back to the nominal quarter-period setting, which is the master code alone with no trim. The path can then be margined early or late while the loop keeps tracking.

New master codes are accepted only while an active-low update gate is held low. This keeps the path steady during a memory read or write. A flag reports when a requested step could not be taken because the code or the offset was already at its limit. A build-time option ignores the loop entirely: it treats the master code as the maximum delay (255) and the loop as locked. This is meant for low reference frequencies.

Top module: `dly_margin_adj`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `adj_code` is 0 and `at_limit` is 0.
- R2: While `upd_n` is low at a clock edge, the master code is captured as the held code. While `upd_n` is high, the held code keeps its last captured value whatever `mst_code` does.
- R3: `load_n` low at a clock edge sets the trim offset to zero, so `adj_code` equals the held code (nominal 90° setting), and clears `at_limit`. `load_n` takes priority over a move in the same cycle.
- R4: Each falling edge of `move` makes exactly one step. `move` passes through a two-flop synchroniser, and the step shows on `adj_code` by the third clock edge after `move` is seen low. A rising edge of `move`, or holding it at a level, changes nothing.
- R5: `dir` is sampled at the falling edge of `move` through the same synchroniser. `dir`=1 decreases the offset by one step, and `dir`=0 increases it by one step.
- R6: `adj_code` equals the held code plus the signed offset, clamped to 0..255.
- R7: A step up is refused when `adj_code` is already 255 or the offset is at +(2^(OFS_W-1)-1). A step down is refused when `adj_code` is already 0 or the offset is at -(2^(OFS_W-1)-1). A refused step leaves the offset unchanged and sets `at_limit`.
- R8: A step that is taken (including one in the opposite direction after a refused step) clears `at_limit`.
- R9: While `mst_lock` is low, moves are ignored, the offset is forced to zero and `at_limit` is cleared.
- R10: With parameter `FORCE_MAX`=1, the effective master code is 255 and lock is treated as true whatever `mst_code` and `mst_lock` show.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mst_code | input | 8 | Master delay code from the loop |
| mst_lock | input | 1 | Loop lock indication |
| upd_n | input | 1 | Active-low gate for accepting a new master code |
| load_n | input | 1 | Active-low return to nominal (zero offset) |
| move | input | 1 | Step strobe; acts on its falling edge |
| dir | input | 1 | Step direction: 1 = less delay, 0 = more delay |
| adj_code | output | 8 | Adjusted delay code |
| at_limit | output | 1 | Last requested step was refused at a limit |

## Verification
Random sequences mix code updates with the gate open and closed, steps in both directions, reloads and lock drops. A bench model tracks the held code, the offset and the flag, so it can tell a captured code from a leaked one and a trim offset from a clamp. Directed runs walk the code into 255 and into 0 and push one step past each. This separates saturation of the output from refusal of the step, and checks that the flag is cleared by a reverse step and by a reload. A strobe whose rising edge is followed by a check before it falls shows that only the falling edge acts. A second instance built with the forced-maximum option and no lock shows the code pinned at 255 and still accepting steps.

// File: rtl/dly_margin_adj.sv
module dly_margin_adj #(
  parameter int FORCE_MAX = 0,
  parameter int OFS_W     = 9
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] mst_code,
  input  logic       mst_lock,
  input  logic       upd_n,
  input  logic       load_n,
  input  logic       move,
  input  logic       dir,
  output logic [7:0] adj_code,
  output logic       at_limit
);
  localparam int SW = OFS_W + 2;
  localparam logic signed [SW-1:0] OMAX = {3'b000, {(OFS_W-1){1'b1}}};
  localparam logic signed [SW-1:0] OMIN = -OMAX;
  localparam logic signed [SW-1:0] CMAX = SW'(255);

  logic [7:0]       held;
  logic [OFS_W-1:0] ofs;
  logic [2:0]       mv_q;
  logic [1:0]       dr_q;
  logic             flag;

  wire [7:0] eff_code = (FORCE_MAX != 0) ? 8'hFF : mst_code;
  wire       lock_eff = (FORCE_MAX != 0) ? 1'b1 : mst_lock;
  wire       fall     = mv_q[2] & ~mv_q[1];
  wire       go_dn    = dr_q[1];

  wire signed [SW-1:0] ofs_x = $signed({{2{ofs[OFS_W-1]}}, ofs});
  wire signed [SW-1:0] sum   = $signed({{(SW-8){1'b0}}, held}) + ofs_x;
  wire up_blk = (sum >= CMAX) || (ofs_x == OMAX);
  wire dn_blk = (sum <= 0)    || (ofs_x == OMIN);

  assign adj_code = sum[SW-1] ? 8'h00 : (sum > CMAX) ? 8'hFF : sum[7:0];
  assign at_limit = flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      mv_q <= '0;
      dr_q <= '0;
    end else begin
      mv_q <= {mv_q[1:0], move};
      dr_q <= {dr_q[0], dir};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         held <= '0;
    else if (!upd_n) held <= eff_code;
  end

  always_ff @(posedge clk) begin
    if (rst || !load_n || !lock_eff) begin
      ofs  <= '0;
      flag <= 1'b0;
    end else if (fall) begin
      if (go_dn ? dn_blk : up_blk) begin
        flag <= 1'b1;
      end else begin
        ofs  <= go_dn ? ofs - OFS_W'(1) : ofs + OFS_W'(1);
        flag <= 1'b0;
      end
    end
  end

  AST_HOLD_GATED: assert property (@(posedge clk) disable iff (rst)
    upd_n |=> $stable(held)); // R2
  AST_LOAD_NOMINAL: assert property (@(posedge clk) disable iff (rst)
    !load_n |=> (adj_code == held) && !at_limit); // R3
  AST_NO_STROBE_STILL: assert property (@(posedge clk) disable iff (rst)
    !fall |=> $stable(ofs) || ofs == '0); // R4
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    (fall && load_n && lock_eff) |=> (ofs == $past(ofs)) ||
      (ofs == $past(ofs) + OFS_W'(1)) || (ofs == $past(ofs) - OFS_W'(1))); // R4
  AST_REFUSED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (fall && load_n && lock_eff && (go_dn ? dn_blk : up_blk)) |=> $stable(ofs) && at_limit); // R7
  AST_UNLOCK_ZERO: assert property (@(posedge clk) disable iff (rst)
    !lock_eff |=> (ofs == '0) && !at_limit); // R9
endmodule

// File: tb/test_dly_margin_adj.sv
module test_dly_margin_adj;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] mst_code = 8'd0;
  logic mst_lock = 1'b0, upd_n = 1'b1, load_n = 1'b1, move = 1'b0, dir = 1'b0;
  logic [7:0] adj_code;
  logic at_limit;
  logic fm_move = 1'b0, fm_dir = 1'b0;
  logic [7:0] fm_code;
  logic fm_lim;

  int checks = 0, fails = 0;
  int m_held = 0, m_ofs = 0;
  bit m_flag = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dly_margin_adj i_dly_margin_adj (.clk(clk), .rst(rst), .mst_code(mst_code), .mst_lock(mst_lock),
    .upd_n(upd_n), .load_n(load_n), .move(move), .dir(dir), .adj_code(adj_code), .at_limit(at_limit));

  dly_margin_adj #(.FORCE_MAX(1)) i_dly_margin_adj_fm (.clk(clk), .rst(rst), .mst_code(8'h10),
    .mst_lock(1'b0), .upd_n(upd_n), .load_n(1'b1), .move(fm_move), .dir(fm_dir),
    .adj_code(fm_code), .at_limit(fm_lim));

  function automatic int clamp(input int v);
    return (v < 0) ? 0 : (v > 255) ? 255 : v;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req);
    chk({req, " code"}, adj_code, clamp(m_held + m_ofs));
    chk({req, " flag"}, at_limit, m_flag);
  endtask

  task automatic upd(input logic [7:0] v);
    @(negedge clk); mst_code = v; upd_n = 1'b0;
    @(negedge clk); upd_n = 1'b1; mst_code = ~v;
    @(negedge clk);
    m_held = v;
  endtask

  task automatic step(input bit d);
    @(negedge clk); dir = d; move = 1'b1;
    repeat (3) @(negedge clk);
    move = 1'b0;
    repeat (4) @(negedge clk);
    if (mst_lock) begin
      if (d ? (clamp(m_held + m_ofs) <= 0 || m_ofs == -255)
            : (clamp(m_held + m_ofs) >= 255 || m_ofs == 255)) m_flag = 1;
      else begin m_ofs += d ? -1 : 1; m_flag = 0; end
    end
  endtask

  task automatic reload();
    @(negedge clk); load_n = 1'b0;
    @(negedge clk); load_n = 1'b1;
    m_ofs = 0; m_flag = 0;
  endtask

  task automatic set_lock(input bit l);
    @(negedge clk); mst_lock = l;
    repeat (2) @(negedge clk);
    if (!l) begin m_ofs = 0; m_flag = 0; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 code", adj_code, 0);
    chk("R1 flag", at_limit, 0);

    set_lock(1);
    upd(8'd100); chk_out("R2 capture");
    @(negedge clk); mst_code = 8'd7; repeat (3) @(negedge clk);
    chk_out("R2 gate closed");

    step(0); chk_out("R5 up");
    step(1); step(1); chk_out("R5 down twice");

    @(negedge clk); dir = 1'b0; move = 1'b1; repeat (4) @(negedge clk);
    chk_out("R4 rising edge no step");
    move = 1'b0; repeat (4) @(negedge clk);
    m_ofs += 1; chk_out("R4 falling edge steps");

    reload(); chk_out("R3 reload");

    upd(8'd252);
    for (int i = 0; i < 3; i++) step(0);
    chk_out("R6 reach 255");
    step(0); chk_out("R7 refused up");
    chk("R7 flag up", at_limit, 1);
    step(1); chk_out("R8 reverse clears");
    chk("R8 flag", at_limit, 0);

    upd(8'd1); reload();
    step(1); step(1); chk_out("R7 refused down");
    chk("R7 flag down", at_limit, 1);
    reload(); chk("R3 flag cleared", at_limit, 0);

    step(0); step(0); upd(8'd254); chk_out("R6 clamp high");

    set_lock(0); chk_out("R9 unlock zero");
    step(0); chk_out("R9 move ignored");
    set_lock(1);

    @(negedge clk); load_n = 1'b0; dir = 1'b0; move = 1'b1;
    repeat (3) @(negedge clk); move = 1'b0;
    repeat (4) @(negedge clk); load_n = 1'b1;
    @(negedge clk); chk_out("R3 load over move");

    chk("R10 forced code", fm_code, 255);
    @(negedge clk); fm_dir = 1'b1; fm_move = 1'b1;
    repeat (3) @(negedge clk); fm_move = 1'b0; repeat (4) @(negedge clk);
    chk("R10 forced lock steps", fm_code, 254);

    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(0, 9);
      if (op < 5)       step(1'($urandom_range(0, 1)));
      else if (op < 7)  upd(8'($urandom_range(0, 255)));
      else if (op == 7) reload();
      else if (op == 8) set_lock(1'($urandom_range(0, 3) != 0));
      else begin
        @(negedge clk); mst_code = 8'($urandom_range(0, 255)); @(negedge clk);
      end
      chk_out("R6 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule